// File: doc/BRIEF.md
# Preconditioned Arithmetic Logic Unit with Status Flags

This block is a purely combinational arithmetic logic unit for two operands of `W` bits (16 by default). It has no decoded opcode. Each operation is built from six independent control bits that act in a fixed order. First, each operand can be cleared to zero. Next, each operand can have every bit inverted. Then one bit selects either a bitwise AND or a two's-complement addition of the two prepared operands. Finally, the result can be inverted on its way out.

With the right control pattern, the same datapath gives constants, pass-through, negation, increment, decrement, sum, difference, AND and OR. Every result comes with a zero flag and a negative flag, both taken from the final output. There is no clock, no register, and no carry or overflow output.

Top module: `precond_alu`

## Requirements
- R1: When `zero_x` is 1, operand x is replaced by all zeros before any other stage. When `zero_y` is 1, operand y is replaced the same way. When a zero control is 0, its operand passes unchanged.
- R2: When `inv_x` (or `inv_y`) is 1, every bit of the operand is inverted after the zero stage. So zero followed by invert yields all ones.
- R3: When `fn_add` is 1, the core result is the sum of the prepared operands modulo 2^W. The carry out of the top bit is discarded, so 0xFFFF + 1 gives 0x0000 and 0x7FFF + 1 gives 0x8000.
- R4: When `fn_add` is 0, the core result is the bitwise AND of the prepared operands.
- R5: When `inv_out` is 1, `result` is the bitwise inverse of the core result. When it is 0, `result` equals the core result.
- R6: `flag_zero` is 1 exactly when all bits of `result` are 0.
- R7: `flag_neg` equals the top bit of `result`, and no other bit affects it.
- R8: The control patterns below, written as zero_x, inv_x, zero_y, inv_y, fn_add, inv_out, give these results:
  - 101010 gives 0; 111111 gives 1; 111010 gives -1.
  - 001100 gives x; 110000 gives y.
  - 001101 gives NOT x; 110001 gives NOT y.
  - 001111 gives -x; 110011 gives -y.
  - 011111 gives x+1; 110111 gives y+1.
  - 001110 gives x-1; 110010 gives y-1.
  - 000010 gives x+y; 010011 gives x-y; 000111 gives y-x.
  - 000000 gives x AND y; 010101 gives x OR y.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_in | input | W | First operand |
| y_in | input | W | Second operand |
| zero_x | input | 1 | Clear operand x |
| inv_x | input | 1 | Invert operand x after clearing |
| zero_y | input | 1 | Clear operand y |
| inv_y | input | 1 | Invert operand y after clearing |
| fn_add | input | 1 | 1: add, 0: bitwise AND |
| inv_out | input | 1 | Invert the core result |
| result | output | W | Final result |
| flag_zero | output | 1 | Result is all zeros |
| flag_neg | output | 1 | Top bit of result |

## Verification
The block holds no state, so any fault shows at the ports as soon as the inputs settle, within the same cycle as the stimulus. A broken carry link shows only for operands whose carries travel far. For that reason the corner operands 0x7FFF, 0x8000 and 0xFFFF are paired with every control pattern, and these pairs expose a stuck or dropped carry at once. A swapped order of the zero and invert stages turns the constant patterns 1 and -1 into wrong values. A flag wired to the wrong bit disagrees with the result on the first operand whose lower bits differ from its top bit.

// File: rtl/alu_pkg.sv
package alu_pkg;
   localparam int unsigned ALU_DEFAULT_W = 16;

   typedef enum logic {
      CORE_AND = 1'b0,
      CORE_ADD = 1'b1
   } core_op_e;
endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] din,
   input  logic         clear,
   input  logic         flip,
   output logic [W-1:0] dout
);
   logic [W-1:0] cleared;

   // clearing comes first, inversion acts on the cleared value
   assign cleared = clear ? '0 : din;
   assign dout    = cleared ^ {W{flip}};
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
   parameter int unsigned W      = 16,
   parameter bit          RIPPLE = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum
);
   generate
      if (W < 2) begin : g_bad_width
         $error("alu_adder: W must be at least 2");
      end

      if (RIPPLE) begin : g_ripple
         always_comb begin
            logic cy;
            // bit 0 is a half adder
            sum[0] = a[0] ^ b[0];
            cy     = a[0] & b[0];
            // upper bits are full adders; final carry dropped
            for (int i = 1; i < W; i++) begin
               sum[i] = a[i] ^ b[i] ^ cy;
               cy     = (a[i] & b[i]) | (cy & (a[i] ^ b[i]));
            end
         end
      end else begin : g_behav
         assign sum = a + b;
      end
   endgenerate
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
   parameter int unsigned W = 16
) (
   input  logic [W-1:0] value,
   output logic         is_zero,
   output logic         is_neg
);
   assign is_zero = ~|value;
   assign is_neg  = value[W-1];
endmodule

// File: rtl/precond_alu.sv
module precond_alu
   import alu_pkg::*;
#(
   parameter int unsigned W      = ALU_DEFAULT_W,
   parameter bit          RIPPLE = 1'b1
) (
   input  logic [W-1:0] x_in,
   input  logic [W-1:0] y_in,
   input  logic         zero_x,
   input  logic         inv_x,
   input  logic         zero_y,
   input  logic         inv_y,
   input  logic         fn_add,
   input  logic         inv_out,
   output logic [W-1:0] result,
   output logic         flag_zero,
   output logic         flag_neg
);
   generate
      if (W < 2) begin : g_bad_width
         $error("precond_alu: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] xp, yp, sum_v, core_v;
   core_op_e     op_sel;

   alu_operand_prep #(.W(W)) u_prep_x (
      .din(x_in), .clear(zero_x), .flip(inv_x), .dout(xp)
   );

   alu_operand_prep #(.W(W)) u_prep_y (
      .din(y_in), .clear(zero_y), .flip(inv_y), .dout(yp)
   );

   alu_adder #(.W(W), .RIPPLE(RIPPLE)) u_add (
      .a(xp), .b(yp), .sum(sum_v)
   );

   assign op_sel = core_op_e'(fn_add);

   always_comb begin
      unique case (op_sel)
         CORE_ADD: core_v = sum_v;
         default:  core_v = xp & yp;
      endcase
   end

   assign result = core_v ^ {W{inv_out}};

   alu_flags #(.W(W)) u_flags (
      .value(result), .is_zero(flag_zero), .is_neg(flag_neg)
   );
endmodule

// File: rtl/precond_alu_chk.sv
module precond_alu_chk #(
   parameter int unsigned W = 16
) (
   input logic [W-1:0] x_in,
   input logic [W-1:0] y_in,
   input logic         zero_x,
   input logic         inv_x,
   input logic         zero_y,
   input logic         inv_y,
   input logic         fn_add,
   input logic         inv_out,
   input logic [W-1:0] result,
   input logic         flag_zero,
   input logic         flag_neg
);
   always_comb begin
      // R6 / R7: a zero result can never carry a set top bit
      a_r6_r7_flags_exclusive: assert (!(flag_zero && flag_neg));

      // R1: both operands cleared, AND core, no inversion -> zero
      if (zero_x && zero_y && !inv_x && !inv_y && !inv_out)
         a_r1_cleared_zero: assert (result == '0);

      // R4: plain AND cannot set a bit absent from x
      if (!fn_add && !inv_x && !inv_y && !inv_out)
         a_r4_and_subset: assert ((result & ~x_in) == '0);

      // R3: adding a cleared y returns x
      if (fn_add && zero_y && !inv_y && !zero_x && !inv_x && !inv_out)
         a_r3_add_identity: assert (result == x_in);

      // R5: inverted plain AND is NAND of the inputs
      if (!fn_add && inv_out && !zero_x && !zero_y && !inv_x && !inv_y)
         a_r5_nand: assert (result == ~(x_in & y_in));

      // R2: cleared and inverted x ANDed with y passes y
      if (!fn_add && zero_x && inv_x && !zero_y && !inv_y && !inv_out)
         a_r2_ones_mask: assert (result == y_in);
   end
endmodule

bind precond_alu precond_alu_chk #(.W(W)) u_chk (.*);

// File: tb/precond_alu_bench.sv
module precond_alu_bench;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 16;
   localparam int WATCHDOG   = 5000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [W-1:0] x_in, y_in, result;
   logic zero_x, inv_x, zero_y, inv_y, fn_add, inv_out;
   logic flag_zero, flag_neg;

   precond_alu #(.W(W)) u_precond_alu (
      .x_in(x_in), .y_in(y_in),
      .zero_x(zero_x), .inv_x(inv_x), .zero_y(zero_y), .inv_y(inv_y),
      .fn_add(fn_add), .inv_out(inv_out),
      .result(result), .flag_zero(flag_zero), .flag_neg(flag_neg)
   );

   typedef struct {
      logic [W-1:0] exp;
      string        tag;
   } item_t;

   item_t q[$];
   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   function automatic logic [W-1:0] ref_fn(input logic [5:0] c,
                                           input logic [W-1:0] x,
                                           input logic [W-1:0] y);
      case (c)
         6'b101010: return '0;
         6'b111111: return 1;
         6'b111010: return '1;
         6'b001100: return x;
         6'b110000: return y;
         6'b001101: return ~x;
         6'b110001: return ~y;
         6'b001111: return -x;
         6'b110011: return -y;
         6'b011111: return x + 1;
         6'b110111: return y + 1;
         6'b001110: return x - 1;
         6'b110010: return y - 1;
         6'b000010: return x + y;
         6'b010011: return x - y;
         6'b000111: return y - x;
         6'b000000: return x & y;
         default:   return x | y;
      endcase
   endfunction

   function automatic string tag_of(input logic [5:0] c);
      case (c)
         6'b101010: return "R1/R8";
         6'b111111, 6'b111010: return "R2/R8";
         6'b000010, 6'b011111: return "R3/R8";
         6'b000000: return "R4/R8";
         6'b001101, 6'b010101: return "R5/R8";
         default:   return "R8";
      endcase
   endfunction

   task automatic drive(input logic [5:0] c, input logic [W-1:0] x,
                        input logic [W-1:0] y, input logic [W-1:0] e,
                        input string tag);
      item_t it;
      @(posedge clk);
      {zero_x, inv_x, zero_y, inv_y, fn_add, inv_out} = c;
      x_in = x;
      y_in = y;
      it.exp = e;
      it.tag = tag;
      q.push_back(it);
   endtask

   // monitor: compare one expected item per cycle, away from the edge
   always @(negedge clk) begin
      if (!rst && q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         checks++;
         if (result !== it.exp) begin
            errors++;
            $display("FAIL %s result: got %h expected %h", it.tag, result, it.exp);
         end
         checks++;
         if (flag_zero !== (it.exp == '0)) begin
            errors++;
            $display("FAIL R6 flag_zero: got %b expected %b", flag_zero, (it.exp == '0));
         end
         checks++;
         if (flag_neg !== it.exp[W-1]) begin
            errors++;
            $display("FAIL R7 flag_neg: got %b expected %b", flag_neg, it.exp[W-1]);
         end
      end
   end

   int cycles = 0;
   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG && !done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: got %0d cycles expected at most %0d", cycles, WATCHDOG);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   localparam logic [5:0] CODES [18] = '{
      6'b101010, 6'b111111, 6'b111010, 6'b001100, 6'b110000, 6'b001101,
      6'b110001, 6'b001111, 6'b110011, 6'b011111, 6'b110111, 6'b001110,
      6'b110010, 6'b000010, 6'b010011, 6'b000111, 6'b000000, 6'b010101};

   localparam logic [W-1:0] VALS [6] = '{
      16'h0000, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h1234, 16'hA5C3};

   initial begin
      {zero_x, inv_x, zero_y, inv_y, fn_add, inv_out} = '0;
      x_in = '0;
      y_in = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // idle state: all inputs low -> AND of zeros, zero flag set (R4, R6)
      drive(6'b000000, 16'h0000, 16'h0000, 16'h0000, "R4 idle");
      // carry out discarded, signed wrap (R3)
      drive(6'b011111, 16'hFFFF, 16'h0000, 16'h0000, "R3 wrap");
      drive(6'b011111, 16'h7FFF, 16'h0000, 16'h8000, "R3 overflow");
      // only the top bit drives the negative flag (R7)
      drive(6'b001100, 16'h7FFF, 16'h0000, 16'h7FFF, "R7 low bits");
      drive(6'b001100, 16'h8000, 16'h0000, 16'h8000, "R7 top bit");
      // zero stage then invert stage ordering (R1, R2)
      drive(6'b111111, 16'hBEEF, 16'h1357, 16'h0001, "R2 order");
      drive(6'b001101, 16'h00FF, 16'h0000, 16'hFF00, "R5 invert out");
      foreach (CODES[ci]) begin
         foreach (VALS[xi]) begin
            foreach (VALS[yi]) begin
               drive(CODES[ci], VALS[xi], VALS[yi],
                     ref_fn(CODES[ci], VALS[xi], VALS[yi]), tag_of(CODES[ci]));
            end
         end
      end
      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule